// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is the bit-manipulation functional unit of a 32-bit RISC-V integer core. It receives an instruction word together with two register operands. It decodes the exact funct7, rs2-field, funct3 and opcode bits of the Zbb and Zba subsets and produces the matching result. The supported operations are:

- counting: leading zeros, trailing zeros and set bits;
- extension: byte and half-word sign extension, half-word zero extension;
- comparison: signed and unsigned minimum and maximum;
- logic with an inverted operand;
- rotation: by register and by immediate;
- byte operations: per-byte OR-combine and byte reversal;
- shift-and-add.

The decode is combinational and the result is registered once, so an operation issued on a strobe is visible on the outputs one clock later. A hit flag tells the surrounding pipeline whether the instruction word belonged to this unit. Words that do not belong to it return a zero result. Register-file access, hazards and traps stay with the core.

Top module: `bmu_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o`, `hit_o` and `result_o` become 0 after that edge.
- R2: `valid_o` equals `valid_i` of the previous edge. `result_o` and `hit_o` load only on an edge where `valid_i` is high and otherwise hold their value.
- R3: Opcode 0010011, funct7 0110000, funct3 001 with field [24:20] = 00000, 00001 or 00010 gives the leading-zero count, trailing-zero count or set-bit count of rs1. A zero rs1 gives 32 for both zero counts.
- R4: Opcode 0010011, funct7 0110000, funct3 001 with field 00100 sign-extends rs1[7:0], and with field 00101 sign-extends rs1[15:0]. Opcode 0110011, funct7 0000100, field 00000, funct3 100 returns rs1[15:0] with the upper half cleared.
- R5: Opcode 0110011, funct7 0000101 selects by funct3: 100 signed min, 101 unsigned min, 110 signed max, 111 unsigned max. Signed forms compare two's complement values.
- R6: Opcode 0110011, funct7 0100000 selects by funct3: 111 gives rs1 AND NOT rs2, 110 gives rs1 OR NOT rs2, 100 gives rs1 XOR NOT rs2.
- R7: Opcode 0110011, funct7 0110000 with funct3 001 rotates rs1 left and with funct3 101 rotates it right, by rs2[4:0]. An amount of 0 returns rs1 unchanged.
- R8: Opcode 0010011, funct7 0110000, funct3 101 rotates rs1 right by instruction bits [24:20] (10100 rotates by 20). rs2 is ignored.
- R9: Opcode 0010011, funct7 0010100, field 00111, funct3 101 sets each result byte to 0xFF when the matching rs1 byte is non-zero, and to 0x00 otherwise.
- R10: Opcode 0010011, funct7 0110100, field 11000, funct3 101 reverses the byte order of rs1 (byte 0 to byte 3, byte 1 to byte 2).
- R11: Opcode 0110011, funct7 0010000 with funct3 010, 100 or 110 returns rs2 + (rs1 << 1), (rs1 << 2) or (rs1 << 3), taken modulo 2^32.
- R12: Any other instruction word loads `hit_o` = 0 and `result_o` = 0. A recognised word loads `hit_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| instr_i | input | 32 | Instruction word |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| valid_o | output | 1 | Result valid, one clock after the strobe |
| hit_o | output | 1 | Instruction word was recognised |
| result_o | output | 32 | Registered result |

## Verification
Every result, the hit flag and the valid flag are due exactly one rising edge after the edge that samples the strobe. No operation takes longer than another. The bench drives each operation on a falling edge and lets one rising edge capture it. It compares all three outputs on the next falling edge, with the strobe already dropped. The hold behaviour is checked in the same way: new operands are presented without a strobe, and on the following falling edge the outputs must still show the earlier result.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] OPC_REG = 7'b0110011;

  typedef enum logic [4:0] {
    OP_NONE, OP_CLZ, OP_CTZ, OP_CPOP, OP_SEXTB, OP_SEXTH, OP_ZEXTH,
    OP_MIN, OP_MINU, OP_MAX, OP_MAXU, OP_ANDN, OP_ORN, OP_XNOR,
    OP_ROL, OP_ROR, OP_RORI, OP_ORCB, OP_REV8, OP_SH1, OP_SH2, OP_SH3
  } bmu_op_e;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
  import bmu_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output bmu_op_e         op,
  output logic            known
);

  logic [6:0] f7;
  logic [4:0] f5;
  logic [2:0] f3;
  logic [6:0] opc;

  assign f7  = instr[31:25];
  assign f5  = instr[24:20];
  assign f3  = instr[14:12];
  assign opc = instr[6:0];

  always_comb begin
    op = OP_NONE;
    if (opc == OPC_IMM) begin
      if (f7 == 7'b0110000 && f3 == 3'b001) begin
        case (f5)
          5'b00000: op = OP_CLZ;
          5'b00001: op = OP_CTZ;
          5'b00010: op = OP_CPOP;
          5'b00100: op = OP_SEXTB;
          5'b00101: op = OP_SEXTH;
          default:  op = OP_NONE;
        endcase
      end else if (f7 == 7'b0110000 && f3 == 3'b101) begin
        op = OP_RORI;
      end else if (f7 == 7'b0010100 && f3 == 3'b101 && f5 == 5'b00111) begin
        op = OP_ORCB;
      end else if (f7 == 7'b0110100 && f3 == 3'b101 && f5 == 5'b11000) begin
        op = OP_REV8;
      end
    end else if (opc == OPC_REG) begin
      case (f7)
        7'b0000101: begin
          case (f3)
            3'b100:  op = OP_MIN;
            3'b101:  op = OP_MINU;
            3'b110:  op = OP_MAX;
            3'b111:  op = OP_MAXU;
            default: op = OP_NONE;
          endcase
        end
        7'b0100000: begin
          case (f3)
            3'b111:  op = OP_ANDN;
            3'b110:  op = OP_ORN;
            3'b100:  op = OP_XNOR;
            default: op = OP_NONE;
          endcase
        end
        7'b0110000: begin
          case (f3)
            3'b001:  op = OP_ROL;
            3'b101:  op = OP_ROR;
            default: op = OP_NONE;
          endcase
        end
        7'b0000100: begin
          if (f3 == 3'b100 && f5 == 5'b00000) op = OP_ZEXTH;
        end
        7'b0010000: begin
          case (f3)
            3'b010:  op = OP_SH1;
            3'b100:  op = OP_SH2;
            3'b110:  op = OP_SH3;
            default: op = OP_NONE;
          endcase
        end
        default: op = OP_NONE;
      endcase
    end
  end

  assign known = (op != OP_NONE);

endmodule

// File: rtl/bmu_bitcount.sv
module bmu_bitcount #(
  parameter int XLEN = 32,
  localparam int CW  = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] val,
  output logic [CW-1:0]   lead,
  output logic [CW-1:0]   trail,
  output logic [CW-1:0]   ones
);

  // leading zeros: the highest set bit wins, later iterations override
  always_comb begin
    lead = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (val[i]) lead = CW'(XLEN - 1 - i);
    end
  end

  // trailing zeros: the lowest set bit wins, scan downward
  always_comb begin
    trail = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (val[i]) trail = CW'(i);
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < XLEN; i++) begin
      ones = ones + CW'(val[i]);
    end
  end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amt,
  input  logic            to_left,
  output logic [XLEN-1:0] dout
);

  // a left rotation by k equals a right rotation by (XLEN - k) mod XLEN
  logic [SHW-1:0]  ramt;
  logic [XLEN-1:0] stg [SHW+1];

  assign ramt   = to_left ? (~amt + SHW'(1)) : amt;
  assign stg[0] = din;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int K = 1 << g;
    assign stg[g+1] = ramt[g] ? {stg[g][K-1:0], stg[g][XLEN-1:K]} : stg[g];
  end

  assign dout = stg[SHW];

endmodule

// File: rtl/bmu_exec_unit.sv
module bmu_exec_unit
  import bmu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN),
  localparam int CW  = $clog2(XLEN + 1),
  localparam int NB  = XLEN / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            valid_o,
  output logic            hit_o,
  output logic [XLEN-1:0] result_o
);

  bmu_op_e         op;
  logic            known;
  logic [CW-1:0]   n_lead, n_trail, n_ones;
  logic [SHW-1:0]  rot_amt;
  logic [XLEN-1:0] rot_out;
  logic [XLEN-1:0] orc_val, rev_val;
  logic            lt_s, lt_u;
  logic [XLEN-1:0] res_d;

  bmu_decode u_dec (
    .instr (instr_i),
    .op    (op),
    .known (known)
  );

  bmu_bitcount #(.XLEN(XLEN)) u_cnt (
    .val   (rs1_i),
    .lead  (n_lead),
    .trail (n_trail),
    .ones  (n_ones)
  );

  // immediate rotate takes its amount from the rs2 field of the word
  assign rot_amt = (op == OP_RORI) ? instr_i[20 +: SHW] : rs2_i[SHW-1:0];

  bmu_rotate #(.XLEN(XLEN)) u_rot (
    .din     (rs1_i),
    .amt     (rot_amt),
    .to_left (op == OP_ROL),
    .dout    (rot_out)
  );

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign orc_val[8*b +: 8] = {8{|rs1_i[8*b +: 8]}};
    assign rev_val[8*b +: 8] = rs1_i[8*(NB-1-b) +: 8];
  end

  assign lt_s = $signed(rs1_i) < $signed(rs2_i);
  assign lt_u = rs1_i < rs2_i;

  always_comb begin
    case (op)
      OP_CLZ:   res_d = XLEN'(n_lead);
      OP_CTZ:   res_d = XLEN'(n_trail);
      OP_CPOP:  res_d = XLEN'(n_ones);
      OP_SEXTB: res_d = {{(XLEN-8){rs1_i[7]}}, rs1_i[7:0]};
      OP_SEXTH: res_d = {{(XLEN-16){rs1_i[15]}}, rs1_i[15:0]};
      OP_ZEXTH: res_d = {{(XLEN-16){1'b0}}, rs1_i[15:0]};
      OP_MIN:   res_d = lt_s ? rs1_i : rs2_i;
      OP_MINU:  res_d = lt_u ? rs1_i : rs2_i;
      OP_MAX:   res_d = lt_s ? rs2_i : rs1_i;
      OP_MAXU:  res_d = lt_u ? rs2_i : rs1_i;
      OP_ANDN:  res_d = rs1_i & ~rs2_i;
      OP_ORN:   res_d = rs1_i | ~rs2_i;
      OP_XNOR:  res_d = rs1_i ^ ~rs2_i;
      OP_ROL, OP_ROR, OP_RORI: res_d = rot_out;
      OP_ORCB:  res_d = orc_val;
      OP_REV8:  res_d = rev_val;
      OP_SH1:   res_d = rs2_i + {rs1_i[XLEN-2:0], 1'b0};
      OP_SH2:   res_d = rs2_i + {rs1_i[XLEN-3:0], 2'b0};
      OP_SH3:   res_d = rs2_i + {rs1_i[XLEN-4:0], 3'b0};
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      hit_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hit_o    <= known;
        result_o <= res_d;
      end
    end
  end

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!valid_o && !hit_o && result_o == '0));

  // R2: valid follows the strobe by one edge
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);
  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(hit_o)));

  // R3: a zero operand yields the full width for leading-zero count
  a_r3_clz_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_i && op == OP_CLZ && rs1_i == '0) |=> (result_o == XLEN'(XLEN)));

  // R12: an unrecognised word leaves a zero result
  a_r12_miss_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !hit_o) |-> (result_o == '0));

endmodule

// File: tb/test_bmu_exec_unit.sv
module test_bmu_exec_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs1_i = '0;
  logic [31:0] rs2_i = '0;
  logic        valid_o, hit_o;
  logic [31:0] result_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bmu_exec_unit i_bmu_exec_unit (
    .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .valid_o(valid_o), .hit_o(hit_o),
    .result_o(result_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] word(input logic [6:0] f7, input logic [4:0] f5,
                                       input logic [2:0] f3, input logic [6:0] opc);
    return {f7, f5, 5'd11, f3, 5'd12, opc};
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] a, input int k);
    logic [63:0] d;
    d = {a, a} >> k;
    return d[31:0];
  endfunction

  // reference model; tag names the requirement the operation belongs to
  function automatic void model(input logic [31:0] w, input logic [31:0] a,
                                input logic [31:0] b, output logic h,
                                output logic [31:0] r, output string tag);
    logic [6:0] f7 = w[31:25];
    logic [4:0] f5 = w[24:20];
    logic [2:0] f3 = w[14:12];
    logic [6:0] oc = w[6:0];
    int n;
    h = 1'b1; r = '0; tag = "R12";
    if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b001 && f5 == 5'd0) begin
      n = 0; while (n < 32 && !a[31-n]) n++; r = n; tag = "R3";
    end else if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b001 && f5 == 5'd1) begin
      n = 0; while (n < 32 && !a[n]) n++; r = n; tag = "R3";
    end else if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b001 && f5 == 5'd2) begin
      r = $countones(a); tag = "R3";
    end else if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b001 && f5 == 5'd4) begin
      r = 32'($signed(a[7:0])); tag = "R4";
    end else if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b001 && f5 == 5'd5) begin
      r = 32'($signed(a[15:0])); tag = "R4";
    end else if (oc == 7'b0110011 && f7 == 7'b0000100 && f3 == 3'b100 && f5 == 5'd0) begin
      r = a & 32'h0000FFFF; tag = "R4";
    end else if (oc == 7'b0110011 && f7 == 7'b0000101 && f3[2]) begin
      tag = "R5";
      case (f3[1:0])
        2'b00: r = ($signed(a) < $signed(b)) ? a : b;
        2'b01: r = (a < b) ? a : b;
        2'b10: r = ($signed(a) > $signed(b)) ? a : b;
        default: r = (a > b) ? a : b;
      endcase
    end else if (oc == 7'b0110011 && f7 == 7'b0100000 &&
                 (f3 == 3'b111 || f3 == 3'b110 || f3 == 3'b100)) begin
      tag = "R6";
      r = (f3 == 3'b111) ? (a & ~b) : (f3 == 3'b110) ? (a | ~b) : ~(a ^ b);
    end else if (oc == 7'b0110011 && f7 == 7'b0110000 && f3 == 3'b001) begin
      r = rotr(a, (32 - int'(b[4:0])) % 32); tag = "R7";
    end else if (oc == 7'b0110011 && f7 == 7'b0110000 && f3 == 3'b101) begin
      r = rotr(a, int'(b[4:0])); tag = "R7";
    end else if (oc == 7'b0010011 && f7 == 7'b0110000 && f3 == 3'b101) begin
      r = rotr(a, int'(f5)); tag = "R8";
    end else if (oc == 7'b0010011 && f7 == 7'b0010100 && f3 == 3'b101 && f5 == 5'b00111) begin
      for (int i = 0; i < 4; i++) if (a[8*i +: 8] != 0) r[8*i +: 8] = 8'hFF;
      tag = "R9";
    end else if (oc == 7'b0010011 && f7 == 7'b0110100 && f3 == 3'b101 && f5 == 5'b11000) begin
      r = {a[7:0], a[15:8], a[23:16], a[31:24]}; tag = "R10";
    end else if (oc == 7'b0110011 && f7 == 7'b0010000 &&
                 (f3 == 3'b010 || f3 == 3'b100 || f3 == 3'b110)) begin
      r = b + a * (32'd1 << f3[2:1]); tag = "R11";
    end else begin
      h = 1'b0;
    end
  endfunction

  task automatic expect_eq(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic h; logic [31:0] r; string tag;
    model(w, a, b, h, r, tag);
    @(negedge clk);
    valid_i = 1'b1; instr_i = w; rs1_i = a; rs2_i = b;
    @(negedge clk);
    valid_i = 1'b0;
    expect_eq("R2", "valid", 32'(valid_o), 32'd1);
    expect_eq(tag, "hit", 32'(hit_o), 32'(h));
    expect_eq(tag, "result", result_o, r);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  logic [31:0] ops [26];
  logic [31:0] pats [8];

  initial begin
    logic [31:0] seed, sa, sb, held;
    ops[0]  = word(7'b0110000, 5'd0, 3'b001, 7'b0010011);
    ops[1]  = word(7'b0110000, 5'd1, 3'b001, 7'b0010011);
    ops[2]  = word(7'b0110000, 5'd2, 3'b001, 7'b0010011);
    ops[3]  = word(7'b0110000, 5'd4, 3'b001, 7'b0010011);
    ops[4]  = word(7'b0110000, 5'd5, 3'b001, 7'b0010011);
    ops[5]  = word(7'b0000100, 5'd0, 3'b100, 7'b0110011);
    ops[6]  = word(7'b0000101, 5'd11, 3'b100, 7'b0110011);
    ops[7]  = word(7'b0000101, 5'd11, 3'b101, 7'b0110011);
    ops[8]  = word(7'b0000101, 5'd11, 3'b110, 7'b0110011);
    ops[9]  = word(7'b0000101, 5'd11, 3'b111, 7'b0110011);
    ops[10] = word(7'b0100000, 5'd11, 3'b111, 7'b0110011);
    ops[11] = word(7'b0100000, 5'd11, 3'b110, 7'b0110011);
    ops[12] = word(7'b0100000, 5'd11, 3'b100, 7'b0110011);
    ops[13] = word(7'b0110000, 5'd11, 3'b001, 7'b0110011);
    ops[14] = word(7'b0110000, 5'd11, 3'b101, 7'b0110011);
    ops[15] = word(7'b0010100, 5'b00111, 3'b101, 7'b0010011);
    ops[16] = word(7'b0110100, 5'b11000, 3'b101, 7'b0010011);
    ops[17] = word(7'b0010000, 5'd11, 3'b010, 7'b0110011);
    ops[18] = word(7'b0010000, 5'd11, 3'b100, 7'b0110011);
    ops[19] = word(7'b0010000, 5'd11, 3'b110, 7'b0110011);
    ops[20] = word(7'b0110000, 5'd3, 3'b001, 7'b0010011);   // R12 gap in field
    ops[21] = word(7'b0000000, 5'd11, 3'b000, 7'b0110011);  // R12 plain add
    ops[22] = word(7'b0000100, 5'd1, 3'b100, 7'b0110011);   // R12 bad field
    ops[23] = word(7'b0010100, 5'd6, 3'b101, 7'b0010011);   // R12 bad field
    ops[24] = word(7'b0000101, 5'd11, 3'b000, 7'b0110011);  // R12 bad funct3
    ops[25] = word(7'b0110000, 5'd0, 3'b001, 7'b0110111);   // R12 other opcode
    pats[0] = 32'h0; pats[1] = 32'hFFFFFFFF; pats[2] = 32'h80000000;
    pats[3] = 32'h00000001; pats[4] = 32'h7FFFFFFF; pats[5] = 32'h00FF0080;
    pats[6] = 32'h12345678; pats[7] = 32'hFFFF8000;

    // R1: reset state
    repeat (3) @(negedge clk);
    expect_eq("R1", "valid", 32'(valid_o), 32'd0);
    expect_eq("R1", "hit", 32'(hit_o), 32'd0);
    expect_eq("R1", "result", result_o, 32'd0);
    rst = 1'b0;

    // corner operands for every encoding
    for (int o = 0; o < 26; o++)
      for (int p = 0; p < 8; p++)
        issue(ops[o], pats[p], pats[7-p]);

    // pseudo-random operands for every encoding
    seed = 32'h1F2E3D4C;
    for (int o = 0; o < 26; o++)
      for (int k = 0; k < 40; k++) begin
        sa = xs(seed); sb = xs(sa); seed = sb;
        issue(ops[o], sa, sb);
      end

    // R7: every rotate amount, including 0, in both directions
    for (int k = 0; k < 32; k++) begin
      issue(ops[13], 32'hA5C3_0F01, 32'hFFFF_FFE0 | 32'(k));
      issue(ops[14], 32'hA5C3_0F01, 32'h0000_0100 | 32'(k));
    end

    // R8: every immediate amount, rs2 holds a distracting value
    for (int k = 0; k < 32; k++)
      issue(word(7'b0110000, 5'(k), 3'b101, 7'b0010011), 32'hDEAD_B00F, 32'h0000_0003);

    // R2: no strobe, new inputs must not disturb the outputs
    issue(ops[10], 32'hF0F0_1234, 32'h0F00_0004);
    held = result_o;
    @(negedge clk);
    instr_i = ops[2]; rs1_i = 32'hFFFF_FFFF; rs2_i = 32'h1;
    @(negedge clk);
    expect_eq("R2", "valid without strobe", 32'(valid_o), 32'd0);
    expect_eq("R2", "result held", result_o, held);
    expect_eq("R2", "hit held", 32'(hit_o), 32'd1);

    // R1: reset mid-run clears a live result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expect_eq("R1", "valid after reset", 32'(valid_o), 32'd0);
    expect_eq("R1", "result after reset", result_o, 32'd0);
    expect_eq("R1", "hit after reset", 32'(hit_o), 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule